// File: doc/BRIEF.md
# Translation Unit Control and Status Register File

This block is the software-visible control point of an address translation unit. It contains four 32-bit registers: a root pointer for the privileged translation tree, a root pointer for the unprivileged tree, a lookaside-buffer control register, and a command/status register. A processor reaches the registers through a simple single-cycle bus. Every register can be accessed as a full 32-bit word or as either of its two 16-bit halves.

Some accesses have side effects. Writing a root pointer discards all cached translations and cache lines that belong to that privilege space, even when the value written equals the old one. Writes and reads of the lookaside-buffer control register discard translations. Changing the external-cache enable discards the whole external cache. Each discard request leaves the block as a one-cycle strobe. The strobe comes from a flop that is loaded on the clock edge that completes the access.

The fault detectors outside the block drive four fault inputs. Each input sets a sticky status bit. A sticky bit stays set until software writes a zero into it. The command register also drives the enables for the caches, the floating-point coprocessor and the two translation spaces.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, all enables are low and no strobe is active.
- R2: Register select is `bus_addr[3:2]`: 0 is the privileged root, 1 the unprivileged root, 2 lookaside control, 3 command/status. A root pointer keeps the low 20 bits written, reads back with bits 31:20 zero, and appears on its root output. The root pointer changes only when it is written.
- R3: When `bus_half` is high, `bus_addr[1]`=1 selects bits 15:0 and `bus_addr[1]`=0 selects bits 31:16. Write data is taken from `bus_wdata[15:0]`. Read data is returned on `bus_rdata[15:0]` with the upper 16 bits zero. The unselected half is not changed.
- R4: Any write to root pointer 1 pulses `tlb_flush_usr` and `xc_flush_usr` for exactly the one cycle after the access. This holds for either half and for an unchanged value. Root pointer 0 does the same on `tlb_flush_sup` and `xc_flush_sup`. When no such access occurs, no strobe is raised.
- R5: A write to lookaside control pulses `tlb_flush_sup` if the written bit 15 is 1 and `tlb_flush_usr` if it is 0. This applies to full words and to the lower half. A write to the upper half has no effect. Lookaside control always reads zero.
- R6: Any read of lookaside control pulses both `tlb_flush_usr` and `tlb_flush_sup`.
- R7: Command bits drive the enables: bit 6 `en_fpu`, bit 5 `en_icache`, bit 2 `en_xcache`, bit 1 `en_map_sup`, bit 0 `en_map_usr`. Each bit reads back what was written.
- R8: A write that changes command bit 2 pulses `xc_flush_all` for one cycle. A write that leaves bit 2 unchanged does not.
- R9: `flt_in[3]`, `flt_in[2]`, `flt_in[1]` and `flt_in[0]` set status bits 15 (table fault), 14 (page fault), 13 (protection fault) and 3 (bus error). A status bit stays set until a status write carries a 0 in that bit position. Writing 1 to the bit leaves it unchanged.
- R10: When a fault input and a status write that clears the same bit occur in the same cycle, the bit ends up set.
- R11: Status bits 31:16, 12:7 and 4 read zero. A write to the upper half of the status register changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 16-bit access |
| bus_addr | input | 4 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| flt_in | input | 4 | Fault set requests: table, page, protection, bus error |
| root_sup | output | PFN_W | Privileged tree root frame |
| root_usr | output | PFN_W | Unprivileged tree root frame |
| en_fpu | output | 1 | Coprocessor enable |
| en_icache | output | 1 | Processor instruction cache enable |
| en_xcache | output | 1 | External cache enable |
| en_map_sup | output | 1 | Privileged translation enable |
| en_map_usr | output | 1 | Unprivileged translation enable |
| tlb_flush_usr | output | 1 | Discard unprivileged translations |
| tlb_flush_sup | output | 1 | Discard privileged translations |
| xc_flush_usr | output | 1 | Discard unprivileged external cache lines |
| xc_flush_sup | output | 1 | Discard privileged external cache lines |
| xc_flush_all | output | 1 | Discard the whole external cache |

## Verification
The hardest case to reach from the ports is a fault input arriving in the same cycle as a software write that clears the bit it sets. Random traffic almost never produces this, so the stimulus includes directed accesses that raise a fault input and write zeros to the status register together. The stimulus also covers a rewrite of an unchanged root pointer, which must still produce strobes, and a half-word write that touches only the unused upper half of a register. Random word and half-word traffic with sparse fault pulses then runs against a reference model in the bench.

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs #(
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_half,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [3:0]       flt_in,
  output logic [PFN_W-1:0] root_sup,
  output logic [PFN_W-1:0] root_usr,
  output logic             en_fpu,
  output logic             en_icache,
  output logic             en_xcache,
  output logic             en_map_sup,
  output logic             en_map_usr,
  output logic             tlb_flush_usr,
  output logic             tlb_flush_sup,
  output logic             xc_flush_usr,
  output logic             xc_flush_sup,
  output logic             xc_flush_all
);
  localparam int PAD_W = 32 - PFN_W;

  logic [4:0]  ctl;
  logic [3:0]  stk;
  logic [31:0] wmask, wval, cur, mrg, v_stat;
  logic [1:0]  rsel;
  logic        wr, rd, wr_stat;

  assign rsel  = bus_addr[3:2];
  assign wr    = bus_sel & bus_wr;
  assign rd    = bus_sel & ~bus_wr;
  assign wmask = !bus_half ? 32'hFFFF_FFFF : (bus_addr[1] ? 32'h0000_FFFF : 32'hFFFF_0000);
  assign wval  = bus_half ? {2{bus_wdata[15:0]}} : bus_wdata;

  assign v_stat = {16'h0, stk[3], stk[2], stk[1], 6'h0, ctl[4], ctl[3], 1'b0,
                   stk[0], ctl[2], ctl[1], ctl[0]};

  always_comb begin
    case (rsel)
      2'd0:    cur = {{PAD_W{1'b0}}, root_sup};
      2'd1:    cur = {{PAD_W{1'b0}}, root_usr};
      2'd2:    cur = 32'h0;
      default: cur = v_stat;
    endcase
  end

  assign mrg = (cur & ~wmask) | (wval & wmask);
  assign bus_rdata = !rd ? 32'h0 :
                     !bus_half ? cur :
                     bus_addr[1] ? {16'h0, cur[15:0]} : {16'h0, cur[31:16]};

  assign wr_stat = wr && rsel == 2'd3;

  assign en_fpu     = ctl[4];
  assign en_icache  = ctl[3];
  assign en_xcache  = ctl[2];
  assign en_map_sup = ctl[1];
  assign en_map_usr = ctl[0];

  logic tlb_wr;
  assign tlb_wr = wr && rsel == 2'd2 && wmask[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_sup      <= '0;
      root_usr      <= '0;
      ctl           <= '0;
      stk           <= '0;
      tlb_flush_usr <= 1'b0;
      tlb_flush_sup <= 1'b0;
      xc_flush_usr  <= 1'b0;
      xc_flush_sup  <= 1'b0;
      xc_flush_all  <= 1'b0;
    end else begin
      if (wr && rsel == 2'd0) root_sup <= mrg[PFN_W-1:0];
      if (wr && rsel == 2'd1) root_usr <= mrg[PFN_W-1:0];
      if (wr_stat) ctl <= {mrg[6], mrg[5], mrg[2], mrg[1], mrg[0]};
      stk <= (wr_stat ? (stk & {mrg[15], mrg[14], mrg[13], mrg[3]}) : stk) | flt_in;
      xc_flush_sup  <= wr && rsel == 2'd0;
      xc_flush_usr  <= wr && rsel == 2'd1;
      tlb_flush_sup <= (wr && rsel == 2'd0) || (tlb_wr && wval[15]) || (rd && rsel == 2'd2);
      tlb_flush_usr <= (wr && rsel == 2'd1) || (tlb_wr && !wval[15]) || (rd && rsel == 2'd2);
      xc_flush_all  <= wr_stat && (mrg[2] != ctl[2]);
    end
  end

  p_usr_flush_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xc_flush_usr |-> $past(bus_sel) && $past(bus_wr));
  p_tlb_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_flush_usr || tlb_flush_sup) |-> $past(bus_sel));
  p_xc_all_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xc_flush_all |-> en_xcache != $past(en_xcache));
  p_root_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_sel) && $past(bus_wr)) |-> $stable(root_usr) && $stable(root_sup));
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stat) |-> (($past(stk) & ~stk) == 4'h0));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flt_in) & ~stk) == 4'h0);
endmodule

// File: tb/mmu_ctrl_regs_tb_top.sv
module mmu_ctrl_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_half = 0;
  logic [3:0] bus_addr = 0, flt_in = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [19:0] root_sup, root_usr;
  logic en_fpu, en_icache, en_xcache, en_map_sup, en_map_usr;
  logic tlb_flush_usr, tlb_flush_sup, xc_flush_usr, xc_flush_sup, xc_flush_all;

  always #2.5 clk = ~clk;

  mmu_ctrl_regs dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [19:0] m_sup = 0, m_usr = 0;
  logic [4:0]  m_ctl = 0;
  logic [3:0]  m_stk = 0;

  function automatic logic [31:0] view(logic [1:0] r);
    case (r)
      2'd0: return {12'h0, m_sup};
      2'd1: return {12'h0, m_usr};
      2'd2: return 32'h0;
      default: return {16'h0, m_stk[3], m_stk[2], m_stk[1], 6'h0, m_ctl[4], m_ctl[3],
                       1'b0, m_stk[0], m_ctl[2], m_ctl[1], m_ctl[0]};
    endcase
  endfunction

  function automatic logic [31:0] hmask(bit half, logic [3:0] a);
    return !half ? 32'hFFFF_FFFF : (a[1] ? 32'h0000_FFFF : 32'hFFFF_0000);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(bit wr, logic [3:0] a, bit half, logic [31:0] d, logic [3:0] f);
    logic [1:0]  r = a[3:2];
    logic [31:0] cur = view(r);
    logic [31:0] mk = hmask(half, a);
    logic [31:0] wv = half ? {2{d[15:0]}} : d;
    logic [31:0] mg = (cur & ~mk) | (wv & mk);
    logic [31:0] erd = !half ? cur : (a[1] ? {16'h0, cur[15:0]} : {16'h0, cur[31:16]});
    bit e_tu, e_ts, e_xu, e_xs, e_xa;
    e_xs = wr && r == 0;
    e_xu = wr && r == 1;
    e_ts = e_xs || (wr && r == 2 && mk[15] && wv[15]) || (!wr && r == 2);
    e_tu = e_xu || (wr && r == 2 && mk[15] && !wv[15]) || (!wr && r == 2);
    e_xa = wr && r == 3 && (mg[2] != m_ctl[2]);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_half = half; bus_wdata = d; flt_in = f;
    #1;
    if (!wr) chk(r == 2 ? "R5" : (half ? "R3" : (r == 3 ? "R11" : "R2")), bus_rdata, erd);
    if (wr && r == 0) m_sup = mg[19:0];
    if (wr && r == 1) m_usr = mg[19:0];
    if (wr && r == 3) begin
      m_ctl = {mg[6], mg[5], mg[2], mg[1], mg[0]};
      m_stk = m_stk & {mg[15], mg[14], mg[13], mg[3]};
    end
    m_stk = m_stk | f;
    @(negedge clk);
    bus_sel = 0; flt_in = 0;
    chk(!wr && r == 2 ? "R6" : "R4", {28'h0, tlb_flush_usr, tlb_flush_sup, xc_flush_usr, xc_flush_sup},
        {28'h0, e_tu, e_ts, e_xu, e_xs});
    chk("R8", {31'h0, xc_flush_all}, {31'h0, e_xa});
    chk("R7", {27'h0, en_fpu, en_icache, en_xcache, en_map_sup, en_map_usr}, {27'h0, m_ctl});
    chk("R2", {root_sup, 12'h0}, {m_sup, 12'h0});
    chk("R2", {root_usr, 12'h0}, {m_usr, 12'h0});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {root_sup, root_usr}, 40'h0);
    chk("R1", {27'h0, en_fpu, en_icache, en_xcache, en_map_sup, en_map_usr,
               tlb_flush_usr, tlb_flush_sup, xc_flush_usr, xc_flush_sup, xc_flush_all}, 32'h0);
    acc(0, 4'hC, 0, 0, 0);
    acc(0, 4'h0, 0, 0, 0);
    // R2 full word root pointers, upper bits dropped
    acc(1, 4'h4, 0, 32'hABCD_1234, 0);
    acc(0, 4'h4, 0, 0, 0);
    acc(1, 4'h0, 0, 32'hFFFF_FFFF, 0);
    // R4 rewrite of unchanged value still flushes
    acc(1, 4'h4, 0, 32'hABCD_1234, 0);
    // R3 half accesses
    acc(1, 4'h6, 1, 32'h0000_5A5A, 0);
    acc(1, 4'h4, 1, 32'h0000_0007, 0);
    acc(0, 4'h6, 1, 0, 0);
    acc(0, 4'h4, 1, 0, 0);
    // R5 lookaside control writes
    acc(1, 4'h8, 0, 32'h0, 0);
    acc(1, 4'h8, 0, 32'h8000, 0);
    acc(1, 4'hA, 1, 32'h8000, 0);
    acc(1, 4'h8, 1, 32'h8000, 0);
    // R6 lookaside read flushes both
    acc(0, 4'h8, 0, 0, 0);
    acc(0, 4'hA, 1, 0, 0);
    // R7/R8 enables and toggle of the cache enable
    acc(1, 4'hC, 0, 32'h0000_0067, 0);
    acc(1, 4'hC, 0, 32'h0000_0067, 0);
    acc(1, 4'hC, 0, 32'h0000_0063, 0);
    // R9 sticky set, write 1 keeps, write 0 clears
    acc(0, 4'hC, 0, 0, 4'hF);
    acc(0, 4'hC, 0, 0, 0);
    acc(1, 4'hC, 0, 32'h0000_E00B, 0);
    acc(0, 4'hC, 0, 0, 0);
    acc(1, 4'hC, 0, 32'h0000_0003, 0);
    acc(0, 4'hC, 0, 0, 0);
    // R10 set wins over same-cycle clear
    acc(0, 4'hC, 0, 0, 4'h5);
    acc(1, 4'hC, 0, 32'h0, 4'h4);
    acc(0, 4'hC, 0, 0, 0);
    chk("R10", {28'h0, m_stk}, 32'h4);
    // R11 upper half of status ignored, reserved bits zero
    acc(1, 4'hC, 0, 32'hFFFF_FFFF, 0);
    acc(1, 4'hC, 1, 32'h0000_0000, 0);
    acc(0, 4'hC, 0, 0, 0);
    acc(0, 4'hC, 1, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a = {$urandom_range(3, 0), 2'b00};
      bit half = $urandom_range(1, 0);
      if (half) a[1] = $urandom_range(1, 0);
      acc($urandom_range(1, 0), a, half, $urandom,
          ($urandom_range(7, 0) == 0) ? 4'($urandom) : 4'h0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule